// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is a serial test port for a chip's I/O ring. A 16-state controller advances on every rising edge of the test clock under control of the mode-select input. Through it, a tester loads a 3-bit instruction and then moves data through one of three data registers: a one-bit pass-through stage, a 32-bit identification word, or a boundary chain. The boundary chain has one cell per input pad followed by one cell per output pad.

Serial input is taken on the rising edge of the test clock. The serial output is launched on the falling edge, so the far end can capture it on the next rising edge. Boundary instructions capture the live pad and core values. They can preload a pattern and drive it onto the output pads, or they can release every output pad to high impedance while the chain stays reachable. Pads are modelled as plain vectors: a value and an enable per output, with no pad cells.

Top module: `scan_tap_ctrl`

## Requirements
- R1: With `rst_n` low at a rising `tck` edge, the controller enters Test-Logic-Reset and the active instruction becomes IDCODE (001). From the next falling edge, `tdo_en` is 0, all `pad_oe` bits are 1 and `pad_out` equals `core_out`.
- R2: State transitions follow the standard 16-state diagram, with `tms` sampled on each rising `tck` edge. Five consecutive rising edges with `tms` high reach Test-Logic-Reset from any state, and that state forces the active instruction to IDCODE.
- R3: When Capture-IR is left, the instruction stage loads 001. In Shift-IR, the stage moves one place toward bit 0, `tdi` enters bit 2, and bit 0 is presented on `tdo`. The active instruction changes only when Update-IR or Test-Logic-Reset is left.
- R4: `tdo` and `tdo_en` change only on falling `tck` edges. `tdo_en` is 1 exactly while the controller sits in Shift-IR or Shift-DR.
- R5: Under IDCODE (001), Capture-DR loads the 32-bit `ID_VALUE`, which is then shifted out least significant bit first.
- R6: BYPASS (111) and the unassigned codes 011, 101 and 110 select a one-bit stage that captures 0, giving one clock of delay from `tdi` to `tdo`.
- R7: EXTEST (000), SAMPLE/PRELOAD (100) and the high-impedance sample code 010 select the boundary chain of `N_IN+N_OUT` cells. Cell i < N_IN captures `pad_in[i]`, cell N_IN+j captures `core_out[j]`, cell 0 is nearest `tdo`, and the top cell receives `tdi`.
- R8: On leaving Update-DR under a boundary instruction, each output update latch j takes chain cell N_IN+j. Under any other instruction, or in any other state, the latches hold their value.
- R9: While EXTEST is active, `pad_out` equals the output update latches and all `pad_oe` bits are 1.
- R10: While code 010 is active, all `pad_oe` bits are 0.
- R11: Under every instruction other than EXTEST, `pad_out` equals `core_out`. Under every instruction other than 010, `pad_oe` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low reset, sampled on rising `tck` |
| tms | input | 1 | Mode select, steers the state machine |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, launched on falling `tck` |
| tdo_en | output | 1 | High while `tdo` carries shift data |
| pad_in | input | N_IN | Values seen at the input pads |
| core_out | input | N_OUT | Functional values the core wants on the output pads |
| pad_out | output | N_OUT | Value sent to the output pads |
| pad_oe | output | N_OUT | Output pad enable, 1 = drive |

## Verification
The bench builds the block with three input cells and five output cells. With an unequal split, a wrong offset between the input and output halves of the chain, or a swap of the two halves, shows up as misplaced bits in both the captured stream and the driven pads. The identification value has a distinct, non-symmetric pattern, so a reversed or shortened identification register cannot read back correctly. A long pseudo-random walk over `tms`, with the pads changing along the way, reaches the pause and exit states and every reserved code.

// File: rtl/tap_pkg.sv
// Shared definitions for the scan port: controller states, instruction
// codes, data-path selection and the state transition function.
// Assumes a 3-bit instruction register; all other sizes live in modules.
package tap_pkg;

    localparam int IR_W = 3;

    typedef enum logic [3:0] {
        ST_RESET,
        ST_IDLE,
        ST_DR_SEL,
        ST_DR_CAP,
        ST_DR_SHIFT,
        ST_DR_EXIT1,
        ST_DR_PAUSE,
        ST_DR_EXIT2,
        ST_DR_UPD,
        ST_IR_SEL,
        ST_IR_CAP,
        ST_IR_SHIFT,
        ST_IR_EXIT1,
        ST_IR_PAUSE,
        ST_IR_EXIT2,
        ST_IR_UPD
    } tap_state_e;

    localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
    localparam logic [IR_W-1:0] OP_IDCODE  = 3'b001;
    localparam logic [IR_W-1:0] OP_HIZ     = 3'b010;
    localparam logic [IR_W-1:0] OP_SAMPLE  = 3'b100;
    localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;
    localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

    typedef enum logic [1:0] {
        PATH_BYPASS,
        PATH_ID,
        PATH_BOUNDARY
    } dr_path_e;

    // Map an instruction to the data register it places in the scan path.
    function automatic dr_path_e path_of(input logic [IR_W-1:0] op);
        dr_path_e p;
        case (op)
            OP_IDCODE:                    p = PATH_ID;
            OP_EXTEST, OP_HIZ, OP_SAMPLE: p = PATH_BOUNDARY;
            default:                      p = PATH_BYPASS;
        endcase
        return p;
    endfunction

    // Successor state for a given current state and mode-select level.
    function automatic tap_state_e next_state(input tap_state_e s, input logic tms);
        tap_state_e n;
        case (s)
            ST_RESET:    n = tms ? ST_RESET    : ST_IDLE;
            ST_IDLE:     n = tms ? ST_DR_SEL   : ST_IDLE;
            ST_DR_SEL:   n = tms ? ST_IR_SEL   : ST_DR_CAP;
            ST_DR_CAP:   n = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
            ST_DR_SHIFT: n = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
            ST_DR_EXIT1: n = tms ? ST_DR_UPD   : ST_DR_PAUSE;
            ST_DR_PAUSE: n = tms ? ST_DR_EXIT2 : ST_DR_PAUSE;
            ST_DR_EXIT2: n = tms ? ST_DR_UPD   : ST_DR_SHIFT;
            ST_DR_UPD:   n = tms ? ST_DR_SEL   : ST_IDLE;
            ST_IR_SEL:   n = tms ? ST_RESET    : ST_IR_CAP;
            ST_IR_CAP:   n = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
            ST_IR_SHIFT: n = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
            ST_IR_EXIT1: n = tms ? ST_IR_UPD   : ST_IR_PAUSE;
            ST_IR_PAUSE: n = tms ? ST_IR_EXIT2 : ST_IR_PAUSE;
            ST_IR_EXIT2: n = tms ? ST_IR_UPD   : ST_IR_SHIFT;
            default:     n = tms ? ST_DR_SEL   : ST_IDLE;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/tap_fsm.sv
// Controller state register. Advances on rising tck by the standard
// transition function; synchronous active-low reset forces Test-Logic-Reset.
// Assumes tms is stable around the rising edge.
module tap_fsm
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_e state
);

    // State register: reset or step through the diagram.
    always_ff @(posedge tck) begin
        if (!rst_n) state <= ST_RESET;
        else        state <= next_state(state, tms);
    end

    // Checker counter: consecutive rising edges with tms high, saturating at 5.
    logic [2:0] ones_run;
    always_ff @(posedge tck) begin
        if (!rst_n)                    ones_run <= 3'd0;
        else if (!tms)                 ones_run <= 3'd0;
        else if (ones_run != 3'd5)     ones_run <= ones_run + 3'd1;
    end

    assert_five_ones_R2: assert property (@(posedge tck) disable iff (!rst_n)
        (ones_run == 3'd5) |-> (state == ST_RESET));

    assert_sync_reset_R1: assert property (@(posedge tck)
        !rst_n |=> (state == ST_RESET));

endmodule

// File: rtl/tap_ir.sv
// Instruction path: a 3-bit shift stage (capture, shift toward bit 0) and
// the active instruction, which loads from the stage in Update-IR and
// returns to IDCODE in Test-Logic-Reset. Assumes state comes from tap_fsm.
module tap_ir
    import tap_pkg::*;
(
    input  logic            tck,
    input  logic            rst_n,
    input  tap_state_e      state,
    input  logic            tdi,
    output logic [IR_W-1:0] op,
    output logic            ir_so
);

    logic [IR_W-1:0] stage;

    // Shift stage: fixed pattern on capture, serial move in shift.
    always_ff @(posedge tck) begin
        if (!rst_n)                    stage <= IR_CAPTURE;
        else if (state == ST_IR_CAP)   stage <= IR_CAPTURE;
        else if (state == ST_IR_SHIFT) stage <= {tdi, stage[IR_W-1:1]};
    end

    // Active instruction: default on reset, new value on update.
    always_ff @(posedge tck) begin
        if (!rst_n || state == ST_RESET) op <= OP_IDCODE;
        else if (state == ST_IR_UPD)     op <= stage;
    end

    assign ir_so = stage[0];

    assert_capture_pattern_R3: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_IR_CAP) |=> (ir_so == IR_CAPTURE[0]));

    assert_op_hold_R3: assert property (@(posedge tck) disable iff (!rst_n)
        (state != ST_IR_UPD && state != ST_RESET) |=> $stable(op));

    assert_reset_idcode_R1: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_RESET) |=> (op == OP_IDCODE));

endmodule

// File: rtl/tap_dr.sv
// Data registers: one-bit bypass stage, 32-bit identification stage and a
// boundary chain of N_IN input cells below N_OUT output cells, plus the
// output update latches. Only the register chosen by the active
// instruction captures or shifts. Assumes op is stable during a DR scan.
module tap_dr
    import tap_pkg::*;
#(
    parameter int          N_IN     = 4,
    parameter int          N_OUT    = 4,
    parameter logic [31:0] ID_VALUE = 32'h1A2B_C0D5
) (
    input  logic             tck,
    input  logic             rst_n,
    input  tap_state_e       state,
    input  logic [IR_W-1:0]  op,
    input  logic             tdi,
    input  logic [N_IN-1:0]  pad_in,
    input  logic [N_OUT-1:0] core_out,
    output logic             dr_so,
    output logic [N_OUT-1:0] upd_q
);

    localparam int CHAIN_LEN = N_IN + N_OUT;
    localparam int ID_W      = 32;

    dr_path_e path;
    logic     cap_en, shift_en, upd_en;
    logic     byp_q;
    logic [ID_W-1:0]      id_q;
    logic [CHAIN_LEN-1:0] chain_q;

    assign path     = path_of(op);
    assign cap_en   = (state == ST_DR_CAP);
    assign shift_en = (state == ST_DR_SHIFT);
    assign upd_en   = (state == ST_DR_UPD) && (path == PATH_BOUNDARY);

    // Bypass stage: captures zero, passes tdi through one flop.
    always_ff @(posedge tck) begin
        if (!rst_n)                                byp_q <= 1'b0;
        else if (path == PATH_BYPASS && cap_en)    byp_q <= 1'b0;
        else if (path == PATH_BYPASS && shift_en)  byp_q <= tdi;
    end

    // Identification stage: loads the constant, shifts out LSB first.
    always_ff @(posedge tck) begin
        if (!rst_n)                           id_q <= '0;
        else if (path == PATH_ID && cap_en)   id_q <= ID_VALUE;
        else if (path == PATH_ID && shift_en) id_q <= {tdi, id_q[ID_W-1:1]};
    end

    // Boundary chain, one generated cell per pad.
    for (genvar g = 0; g < CHAIN_LEN; g++) begin : g_cell
        logic cap_val;
        logic ser_in;
        if (g < N_IN) begin : g_in
            assign cap_val = pad_in[g];
        end else begin : g_out
            assign cap_val = core_out[g-N_IN];
        end
        if (g == CHAIN_LEN-1) begin : g_top
            assign ser_in = tdi;
        end else begin : g_mid
            assign ser_in = chain_q[g+1];
        end
        // Cell flop: capture the pad or core value, or take the upper neighbour.
        always_ff @(posedge tck) begin
            if (!rst_n)                                 chain_q[g] <= 1'b0;
            else if (path == PATH_BOUNDARY && cap_en)   chain_q[g] <= cap_val;
            else if (path == PATH_BOUNDARY && shift_en) chain_q[g] <= ser_in;
        end
    end

    // Output update latches, one per output cell.
    for (genvar j = 0; j < N_OUT; j++) begin : g_upd
        // Latch: copy the output cell when a boundary update completes.
        always_ff @(posedge tck) begin
            if (!rst_n)      upd_q[j] <= 1'b0;
            else if (upd_en) upd_q[j] <= chain_q[N_IN+j];
        end
    end

    // Serial output of the selected register.
    always_comb begin
        case (path)
            PATH_ID:       dr_so = id_q[0];
            PATH_BOUNDARY: dr_so = chain_q[0];
            default:       dr_so = byp_q;
        endcase
    end

    assert_upd_hold_R8: assert property (@(posedge tck) disable iff (!rst_n)
        !(state == ST_DR_UPD && path == PATH_BOUNDARY) |=> $stable(upd_q));

    assert_bypass_zero_R6: assert property (@(posedge tck) disable iff (!rst_n)
        (cap_en && path == PATH_BYPASS) |=> (dr_so == 1'b0));

    assert_id_lsb_R5: assert property (@(posedge tck) disable iff (!rst_n)
        (cap_en && path == PATH_ID) |=> (dr_so == ID_VALUE[0]));

endmodule

// File: rtl/scan_tap_ctrl.sv
// Top of the scan port: state machine, instruction path, data registers,
// falling-edge serial output and the pad value/enable selection.
// Assumes tck is the only clock and rst_n is synchronous to its rising edge.
module scan_tap_ctrl
    import tap_pkg::*;
#(
    parameter int          N_IN     = 4,
    parameter int          N_OUT    = 4,
    parameter logic [31:0] ID_VALUE = 32'h1A2B_C0D5
) (
    input  logic             tck,
    input  logic             rst_n,
    input  logic             tms,
    input  logic             tdi,
    output logic             tdo,
    output logic             tdo_en,
    input  logic [N_IN-1:0]  pad_in,
    input  logic [N_OUT-1:0] core_out,
    output logic [N_OUT-1:0] pad_out,
    output logic [N_OUT-1:0] pad_oe
);

    tap_state_e      state;
    logic [IR_W-1:0] op;
    logic            ir_so;
    logic            dr_so;
    logic [N_OUT-1:0] upd_q;

    tap_fsm i_fsm (
        .tck   (tck),
        .rst_n (rst_n),
        .tms   (tms),
        .state (state)
    );

    tap_ir i_ir (
        .tck   (tck),
        .rst_n (rst_n),
        .state (state),
        .tdi   (tdi),
        .op    (op),
        .ir_so (ir_so)
    );

    tap_dr #(
        .N_IN     (N_IN),
        .N_OUT    (N_OUT),
        .ID_VALUE (ID_VALUE)
    ) i_dr (
        .tck      (tck),
        .rst_n    (rst_n),
        .state    (state),
        .op       (op),
        .tdi      (tdi),
        .pad_in   (pad_in),
        .core_out (core_out),
        .dr_so    (dr_so),
        .upd_q    (upd_q)
    );

    // Falling-edge launch of the serial output and its valid flag.
    always_ff @(negedge tck) begin
        if (!rst_n) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo    <= (state == ST_IR_SHIFT) ? ir_so : dr_so;
            tdo_en <= (state == ST_IR_SHIFT) || (state == ST_DR_SHIFT);
        end
    end

    // Pad selection: test pattern under EXTEST, released under HIZ.
    assign pad_out = (op == OP_EXTEST) ? upd_q : core_out;
    assign pad_oe  = (op == OP_HIZ) ? '0 : '1;

    assert_tdo_window_R4: assert property (@(posedge tck) disable iff (!rst_n)
        tdo_en == ((state == ST_IR_SHIFT) || (state == ST_DR_SHIFT)));

endmodule

// File: tb/test_scan_tap_ctrl.sv
module test_scan_tap_ctrl;

    localparam int          TCK_PERIOD = 10;
    localparam int          NI  = 3;
    localparam int          NO  = 5;
    localparam int          NB  = NI + NO;
    localparam logic [31:0] IDV = 32'h5EED_0A13;

    logic          tck = 1'b0;
    logic          rst_n = 1'b0;
    logic          tms = 1'b1;
    logic          tdi = 1'b0;
    logic          tdo, tdo_en;
    logic [NI-1:0] pad_in = '0;
    logic [NO-1:0] core_out = '0;
    logic [NO-1:0] pad_out, pad_oe;

    scan_tap_ctrl #(.N_IN(NI), .N_OUT(NO), .ID_VALUE(IDV)) i_scan_tap_ctrl (
        .tck(tck), .rst_n(rst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
        .tdo_en(tdo_en), .pad_in(pad_in), .core_out(core_out),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    always #(TCK_PERIOD/2) tck = ~tck;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    // Reference model state, own numbering.
    localparam int M_TLR = 0, M_RTI = 1, M_SDR = 2, M_CDR = 3, M_SHDR = 4,
                   M_E1DR = 5, M_PDR = 6, M_E2DR = 7, M_UDR = 8, M_SIR = 9,
                   M_CIR = 10, M_SHIR = 11, M_E1IR = 12, M_PIR = 13,
                   M_E2IR = 14, M_UIR = 15;
    int          m_st = M_TLR;
    logic [2:0]  m_ir = 3'b001;
    logic [2:0]  m_irs = 3'b001;
    logic [63:0] m_dr = '0;
    int          m_len = 1;
    logic [NO-1:0] m_upd = '0;
    logic        m_en = 1'b0;
    logic        m_tdo = 1'b0;

    function automatic int m_next(int s, logic t);
        if (s == M_TLR)  return t ? M_TLR : M_RTI;
        if (s == M_RTI || s == M_UDR || s == M_UIR) return t ? M_SDR : M_RTI;
        if (s == M_SDR)  return t ? M_SIR : M_CDR;
        if (s == M_SIR)  return t ? M_TLR : M_CIR;
        if (s == M_CDR || s == M_SHDR) return t ? M_E1DR : M_SHDR;
        if (s == M_CIR || s == M_SHIR) return t ? M_E1IR : M_SHIR;
        if (s == M_E1DR) return t ? M_UDR : M_PDR;
        if (s == M_E1IR) return t ? M_UIR : M_PIR;
        if (s == M_PDR)  return t ? M_E2DR : M_PDR;
        if (s == M_PIR)  return t ? M_E2IR : M_PIR;
        if (s == M_E2DR) return t ? M_UDR : M_SHDR;
        return t ? M_UIR : M_SHIR;
    endfunction

    // 0 bypass, 1 id, 2 boundary
    function automatic int m_sel(logic [2:0] c);
        if (c == 3'b001) return 1;
        if (c == 3'b000 || c == 3'b010 || c == 3'b100) return 2;
        return 0;
    endfunction

    // Advance the model by one rising edge and the following falling edge.
    task automatic model_edge(logic t, logic d);
        if (!rst_n) begin
            m_st = M_TLR; m_ir = 3'b001; m_upd = '0; m_en = 1'b0; m_tdo = 1'b0;
            return;
        end
        case (m_st)
            M_TLR:  m_ir = 3'b001;
            M_CIR:  m_irs = 3'b001;
            M_SHIR: m_irs = {d, m_irs[2:1]};
            M_UIR:  m_ir = m_irs;
            M_CDR: begin
                case (m_sel(m_ir))
                    1:       begin m_dr = {32'h0, IDV}; m_len = 32; end
                    2:       begin m_dr = '0; m_dr[NB-1:0] = {core_out, pad_in}; m_len = NB; end
                    default: begin m_dr = '0; m_len = 1; end
                endcase
            end
            M_SHDR: begin m_dr = m_dr >> 1; m_dr[m_len-1] = d; end
            M_UDR:  if (m_sel(m_ir) == 2) m_upd = m_dr[NB-1:NI];
            default: ;
        endcase
        m_st = m_next(m_st, t);
        m_en = (m_st == M_SHIR) || (m_st == M_SHDR);
        m_tdo = (m_st == M_SHIR) ? m_irs[0] : m_dr[0];
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
        end
    endtask

    // Compare all outputs against the model, just after the falling edge.
    task automatic compare();
        string tr;
        check("R2 R4 tdo_en", 32'(tdo_en), 32'(m_en));
        if (m_en) begin
            if (m_st == M_SHIR) tr = "R3 tdo";
            else if (m_sel(m_ir) == 1) tr = "R5 tdo";
            else if (m_sel(m_ir) == 2) tr = "R7 tdo";
            else tr = "R6 tdo";
            check(tr, 32'(tdo), 32'(m_tdo));
        end
        if (m_ir == 3'b000) check("R8 R9 pad_out", 32'(pad_out), 32'(m_upd));
        else                check("R11 pad_out", 32'(pad_out), 32'(core_out));
        check("R10 R11 pad_oe", 32'(pad_oe), (m_ir == 3'b010) ? 32'h0 : 32'((1 << NO) - 1));
    endtask

    task automatic step(logic t, logic d);
        tms = t; tdi = d;
        model_edge(t, d);
        @(posedge tck);
        @(negedge tck);
        #2;
        compare();
    endtask

    task automatic load_ir(logic [2:0] code);
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 3; i++) step(i == 2, code[i]);
        step(1, 0); step(0, 0);
    endtask

    task automatic scan_dr(int len, logic [63:0] data);
        step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < len; i++) step(i == len - 1, data[i]);
        step(1, 0); step(0, 0);
    endtask

    initial begin
        @(negedge tck); #2;
        for (int i = 0; i < 3; i++) step(1, 0);
        // R1: reset state at the ports
        check("R1 tdo_en", 32'(tdo_en), 32'h0);
        check("R1 pad_oe", 32'(pad_oe), 32'((1 << NO) - 1));
        check("R1 pad_out", 32'(pad_out), 32'(core_out));
        rst_n = 1'b1;
        step(0, 0);
        // R5: identification read under the reset instruction
        scan_dr(32, 64'h0);
        // R6: bypass and reserved codes
        load_ir(3'b111); scan_dr(10, 64'h2B5);
        load_ir(3'b011); scan_dr(6, 64'h2D);
        load_ir(3'b101); scan_dr(6, 64'h16);
        load_ir(3'b110); scan_dr(6, 64'h39);
        // R7 R11: sample and preload
        pad_in = 3'b101; core_out = 5'b10110;
        load_ir(3'b100); scan_dr(NB, 64'hA6);
        // R8 R9: drive the preload, then a new pattern
        load_ir(3'b000);
        core_out = 5'b01001;
        scan_dr(NB, 64'h5B);
        // R8: update under IDCODE leaves latches alone
        load_ir(3'b001); scan_dr(32, 64'hFFFF_FFFF);
        load_ir(3'b000); step(0, 0);
        // R10: high-impedance sample
        pad_in = 3'b010;
        load_ir(3'b010); scan_dr(NB, 64'hC3);
        // R2: pseudo-random walk over the diagram
        for (int i = 0; i < 400; i++) begin
            if (i % 37 == 0) begin pad_in = NI'($urandom); core_out = NO'($urandom); end
            step(1'($urandom), 1'($urandom));
        end
        // R2: five ones return to reset from wherever the walk ended
        for (int i = 0; i < 5; i++) step(1, 0);
        check("R2 tdo_en after five ones", 32'(tdo_en), 32'h0);
        step(0, 0);
        scan_dr(32, 64'h0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(TCK_PERIOD * 150000);
        if (!done) begin
            vectors++; fails++;
            $display("FAIL watchdog R2: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule